// File: doc/BRIEF.md
# CPU Exception Entry Sequencer

This block sits beside a processor pipeline and decides, every clock, whether the core must leave its current instruction stream. Two sources compete: a synchronous exception, presented as a valid flag and a 12-bit event code, and an external interrupt, presented as a request with a 4-bit priority level and its own event code. A pending exception always wins. The block then checks the block bit, the sleep state, the delay-slot state and the interrupt mask to decide whether the event is accepted, dropped, or turned into a reset request.

When an event is accepted, the whole entry happens at one clock edge. The block saves the incoming status word, program counter and stack register into shadow copies. It raises the privileged, register-bank and block bits. It records the event code and computes the handler address from the vector base. The saved PC is corrected for two cases: an event inside a delay slot re-runs the branch, and a trap instruction resumes after itself. A registered `taken` strobe marks the cycle in which the new values appear. The core uses that strobe to load the outputs and to clear its sleep flag.

Top module: `exc_entry_seq`

## Requirements
- R1: While `rst_n` is low, all outputs return to their reset values: `sr_out` = 0x100000F0 (block bit 28 set, mask bits [7:4] = 0xF), `pc_out` = 0xA0000000, and every strobe, shadow register and event-code register is zero.
- R2: When `exc_valid` and `irq_req` are both high in the same cycle, only the exception is considered. `expevt_out` takes the exception code and `intevt_out` keeps its value.
- R3: If status bit 28 (block) is set and an exception with a code other than 0x1E0 is pending, `reset_req` pulses for one cycle on the next edge. `taken` stays low and the PC, status and shadow outputs keep their values. Code 0x1E0 is taken normally even with the block bit set.
- R4: An interrupt is not taken while `in_delay` is high. With the block bit set, an interrupt is also not taken unless `in_sleep` is high.
- R5: An interrupt is taken only if `irq_level` is strictly greater than `sr_in[7:4]`.
- R6: On any accepted event, `ssr_out` gets `sr_in`, `sgr_out` gets `r15_in`, and `sr_out` gets `sr_in` with bits 30 (privileged), 29 (bank) and 28 (block) set.
- R7: If an accepted event arrives with `in_delay` high, `spc_out` is `pc_in` minus 2 and `dslot_clr` pulses together with `taken`. Otherwise `spc_out` starts from `pc_in`.
- R8: Exception codes 0x000, 0x020 and 0x140 load `pc_out` with 0xA0000000, force `sr_out[7:4]` to 0xF and clear `sr_out[15]` (FPU disable).
- R9: Exception codes 0x040 and 0x060 vector to `vbr_in` + 0x400. Every other accepted exception code vectors to `vbr_in` + 0x100. Code 0x160 also adds 2 to the saved PC.
- R10: An accepted interrupt writes `irq_code` to `intevt_out` and vectors to `vbr_in` + 0x600. `expevt_out` keeps its value.
- R11: `taken` is high for exactly the cycle after each accepted event. In cycles with no accepted event, `pc_out`, `sr_out`, the shadow outputs and both event-code outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_valid | input | 1 | An exception is pending this cycle |
| exc_code | input | 12 | Code of the pending exception |
| irq_req | input | 1 | External interrupt request |
| irq_level | input | 4 | Priority level of the request |
| irq_code | input | 12 | Event code of the request |
| sr_in | input | 32 | Current status word |
| pc_in | input | 32 | Current program counter |
| r15_in | input | 32 | Current stack register |
| vbr_in | input | 32 | Vector base |
| in_delay | input | 1 | Core is executing a delay slot |
| in_sleep | input | 1 | Core is sleeping |
| taken | output | 1 | One-cycle strobe: an event was entered |
| reset_req | output | 1 | One-cycle strobe: masked exception, reset wanted |
| dslot_clr | output | 1 | Strobe: clear the delay-slot flag |
| pc_out | output | 32 | Handler address |
| sr_out | output | 32 | Updated status word |
| ssr_out | output | 32 | Saved status word |
| spc_out | output | 32 | Saved program counter |
| sgr_out | output | 32 | Saved stack register |
| expevt_out | output | 12 | Last exception code entered |
| intevt_out | output | 12 | Last interrupt code entered |

## Verification
The bench targets these corner cases:
- Exception and interrupt colliding in one cycle. A design that arbitrated wrongly would overwrite `intevt_out` or vector to +0x600.
- Block bit set with code 0x1E0 versus any other code. A design that got this wrong would either reset on the permitted code or vector on a masked one.
- An interrupt level equal to the mask. An off-by-one compare would take this interrupt.
- Interrupts under the block bit with and without sleep, and during a delay slot.
- A trap inside a delay slot, where the +2 and -2 corrections cancel. A design that applied only one of them would leave `spc_out` two bytes off.
- The reset-class codes. A design that kept the old mask or the FPU-disable bit would leave `sr_out` wrong at the fixed address.

// File: rtl/exc_entry_pkg.sv
// Shared constants and types for the exception entry sequencer.
// Assumes a status word at least 32 bits wide with the bit layout below.
package exc_entry_pkg;
    localparam int SR_MD_BIT   = 30;
    localparam int SR_RB_BIT   = 29;
    localparam int SR_BL_BIT   = 28;
    localparam int SR_FD_BIT   = 15;
    localparam int SR_MASK_LSB = 4;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_EXC   = 2'd1,
        EV_IRQ   = 2'd2,
        EV_RESET = 2'd3
    } ev_kind_t;
endpackage

// File: rtl/code_match.sv
// Compares one event code against a parameter list of codes.
// Assumes LIST packs N codes, entry i at bits [i*CODE_W +: CODE_W].
module code_match #(
    parameter int                      CODE_W = 12,
    parameter int                      N      = 2,
    parameter logic [N*CODE_W-1:0]     LIST   = '0
) (
    input  logic [CODE_W-1:0] code,
    output logic              hit
);
    logic [N-1:0] eq;

    // one comparator per listed code
    generate
        for (genvar i = 0; i < N; i++) begin : g_cmp
            assign eq[i] = (code == LIST[i*CODE_W +: CODE_W]);
        end
    endgenerate

    assign hit = |eq;
endmodule

// File: rtl/evt_arbiter.sv
// Chooses the event class for this cycle: none, exception, interrupt,
// or reset request. An exception always outranks an interrupt.
// Assumes the caller passes the block bit and the interrupt mask already
// extracted from the status word.
module evt_arbiter #(
    parameter int                CODE_W  = 12,
    parameter int                LVL_W   = 4,
    parameter logic [CODE_W-1:0] BL_SAFE = 12'h1E0
) (
    input  logic                      exc_valid,
    input  logic [CODE_W-1:0]         exc_code,
    input  logic                      irq_req,
    input  logic [LVL_W-1:0]          irq_level,
    input  logic                      blk,
    input  logic [LVL_W-1:0]          imask,
    input  logic                      in_delay,
    input  logic                      in_sleep,
    output exc_entry_pkg::ev_kind_t   kind
);
    import exc_entry_pkg::*;

    logic irq_gate;

    // interrupt may enter: no delay slot, block bit clear or sleeping, level above mask
    assign irq_gate = irq_req && !in_delay && (!blk || in_sleep) && (irq_level > imask);

    // priority decision
    always_comb begin
        if (exc_valid) begin
            if (blk && (exc_code != BL_SAFE)) kind = EV_RESET;
            else                              kind = EV_EXC;
        end else if (irq_gate) begin
            kind = EV_IRQ;
        end else begin
            kind = EV_NONE;
        end
    end
endmodule

// File: rtl/entry_vector.sv
// Computes the handler address, updated status word and saved PC for an
// event, assuming it is accepted. Acceptance is decided elsewhere.
// Assumes XLEN >= 32 so the status bit positions exist.
module entry_vector #(
    parameter int                    XLEN      = 32,
    parameter int                    CODE_W    = 12,
    parameter int                    LVL_W     = 4,
    parameter int                    N_HARD    = 3,
    parameter logic [N_HARD*CODE_W-1:0] HARD_LIST = {12'h140, 12'h020, 12'h000},
    parameter int                    N_MISS    = 2,
    parameter logic [N_MISS*CODE_W-1:0] MISS_LIST = {12'h060, 12'h040},
    parameter logic [CODE_W-1:0]     TRAP_CODE = 12'h160,
    parameter logic [XLEN-1:0]       RESET_PC  = 32'hA000_0000,
    parameter logic [XLEN-1:0]       OFS_GEN   = 32'h100,
    parameter logic [XLEN-1:0]       OFS_MISS  = 32'h400,
    parameter logic [XLEN-1:0]       OFS_IRQ   = 32'h600,
    parameter logic [XLEN-1:0]       STEP      = 32'd2
) (
    input  logic              is_irq,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [XLEN-1:0]   sr_in,
    input  logic [XLEN-1:0]   pc_in,
    input  logic [XLEN-1:0]   vbr_in,
    input  logic              in_delay,
    output logic [XLEN-1:0]   nxt_pc,
    output logic [XLEN-1:0]   nxt_sr,
    output logic [XLEN-1:0]   nxt_spc
);
    import exc_entry_pkg::*;

    logic hard_hit, miss_hit, trap_hit;
    logic [XLEN-1:0] sr_raised;

    code_match #(.CODE_W(CODE_W), .N(N_HARD), .LIST(HARD_LIST)) u_hard (
        .code (exc_code),
        .hit  (hard_hit)
    );

    code_match #(.CODE_W(CODE_W), .N(N_MISS), .LIST(MISS_LIST)) u_miss (
        .code (exc_code),
        .hit  (miss_hit)
    );

    assign trap_hit = (exc_code == TRAP_CODE);

    // raise privileged, bank and block bits
    always_comb begin
        sr_raised            = sr_in;
        sr_raised[SR_MD_BIT] = 1'b1;
        sr_raised[SR_RB_BIT] = 1'b1;
        sr_raised[SR_BL_BIT] = 1'b1;
    end

    // handler address and final status word by event class
    always_comb begin
        nxt_sr = sr_raised;
        if (is_irq) begin
            nxt_pc = vbr_in + OFS_IRQ;
        end else if (hard_hit) begin
            nxt_pc                          = RESET_PC;
            nxt_sr[SR_FD_BIT]               = 1'b0;
            nxt_sr[SR_MASK_LSB +: LVL_W]    = '1;
        end else if (miss_hit) begin
            nxt_pc = vbr_in + OFS_MISS;
        end else begin
            nxt_pc = vbr_in + OFS_GEN;
        end
    end

    // saved PC: rewind for delay slot, advance past a trap
    always_comb begin
        nxt_spc = pc_in;
        if (in_delay)             nxt_spc = nxt_spc - STEP;
        if (!is_irq && trap_hit)  nxt_spc = nxt_spc + STEP;
    end
endmodule

// File: rtl/exc_entry_seq.sv
// Exception entry sequencer top. Arbitrates exception against interrupt
// every cycle and, on acceptance, registers the full entry state at one
// edge with a one-cycle taken strobe. Assumes inputs are stable across
// each clock edge and that the core loads pc_out/sr_out on taken.
module exc_entry_seq #(
    parameter int                XLEN     = 32,
    parameter int                CODE_W   = 12,
    parameter int                LVL_W    = 4,
    parameter logic [XLEN-1:0]   RESET_PC = 32'hA000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_valid,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              irq_req,
    input  logic [LVL_W-1:0]  irq_level,
    input  logic [CODE_W-1:0] irq_code,
    input  logic [XLEN-1:0]   sr_in,
    input  logic [XLEN-1:0]   pc_in,
    input  logic [XLEN-1:0]   r15_in,
    input  logic [XLEN-1:0]   vbr_in,
    input  logic              in_delay,
    input  logic              in_sleep,
    output logic              taken,
    output logic              reset_req,
    output logic              dslot_clr,
    output logic [XLEN-1:0]   pc_out,
    output logic [XLEN-1:0]   sr_out,
    output logic [XLEN-1:0]   ssr_out,
    output logic [XLEN-1:0]   spc_out,
    output logic [XLEN-1:0]   sgr_out,
    output logic [CODE_W-1:0] expevt_out,
    output logic [CODE_W-1:0] intevt_out
);
    import exc_entry_pkg::*;

    localparam logic [XLEN-1:0] SR_RESET =
        (XLEN'(1) << SR_BL_BIT) | (XLEN'((1 << LVL_W) - 1) << SR_MASK_LSB);

    ev_kind_t        kind;
    logic            accept;
    logic [XLEN-1:0] nxt_pc, nxt_sr, nxt_spc;

    evt_arbiter #(.CODE_W(CODE_W), .LVL_W(LVL_W)) u_arb (
        .exc_valid (exc_valid),
        .exc_code  (exc_code),
        .irq_req   (irq_req),
        .irq_level (irq_level),
        .blk       (sr_in[SR_BL_BIT]),
        .imask     (sr_in[SR_MASK_LSB +: LVL_W]),
        .in_delay  (in_delay),
        .in_sleep  (in_sleep),
        .kind      (kind)
    );

    entry_vector #(
        .XLEN     (XLEN),
        .CODE_W   (CODE_W),
        .LVL_W    (LVL_W),
        .RESET_PC (RESET_PC)
    ) u_vec (
        .is_irq   (kind == EV_IRQ),
        .exc_code (exc_code),
        .sr_in    (sr_in),
        .pc_in    (pc_in),
        .vbr_in   (vbr_in),
        .in_delay (in_delay),
        .nxt_pc   (nxt_pc),
        .nxt_sr   (nxt_sr),
        .nxt_spc  (nxt_spc)
    );

    assign accept = (kind == EV_EXC) || (kind == EV_IRQ);

    // strobes: one cycle per decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken     <= 1'b0;
            reset_req <= 1'b0;
            dslot_clr <= 1'b0;
        end else begin
            taken     <= accept;
            reset_req <= (kind == EV_RESET);
            dslot_clr <= accept && in_delay;
        end
    end

    // entry state: loaded only when an event is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_out     <= RESET_PC;
            sr_out     <= SR_RESET;
            ssr_out    <= '0;
            spc_out    <= '0;
            sgr_out    <= '0;
            expevt_out <= '0;
            intevt_out <= '0;
        end else if (accept) begin
            pc_out  <= nxt_pc;
            sr_out  <= nxt_sr;
            ssr_out <= sr_in;
            spc_out <= nxt_spc;
            sgr_out <= r15_in;
            if (kind == EV_IRQ) intevt_out <= irq_code;
            else                expevt_out <= exc_code;
        end
    end
endmodule

// File: rtl/exc_entry_chk.sv
// Property checker for the entry sequencer, attached by bind.
// Assumes the default status layout (block bit 28, mask [7:4]).
module exc_entry_chk #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 12,
    parameter int LVL_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exc_valid,
    input logic [CODE_W-1:0] exc_code,
    input logic              irq_req,
    input logic              in_delay,
    input logic [XLEN-1:0]   sr_in,
    input logic [XLEN-1:0]   vbr_in,
    input logic              taken,
    input logic              reset_req,
    input logic [XLEN-1:0]   pc_out,
    input logic [XLEN-1:0]   sr_out,
    input logic [CODE_W-1:0] expevt_out,
    input logic [CODE_W-1:0] intevt_out
);
    // R3
    masked_exc_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && sr_in[28] && exc_code != 12'h1E0) |=> (reset_req && !taken));

    // R2
    exc_beats_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && irq_req && !sr_in[28]) |=> (taken && expevt_out == $past(exc_code)
                                                  && intevt_out == $past(intevt_out)));

    // R4
    no_irq_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_valid && in_delay) |=> !taken);

    // R10
    irq_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_valid && irq_req) |=> (!taken || pc_out == $past(vbr_in) + 32'h600));

    // R6
    entry_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> (sr_out[30] && sr_out[29] && sr_out[28]));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_valid && !irq_req) |=> ($stable(pc_out) && $stable(sr_out) && !taken));
endmodule

bind exc_entry_seq exc_entry_chk #(.XLEN(XLEN), .CODE_W(CODE_W), .LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .exc_valid  (exc_valid),
    .exc_code   (exc_code),
    .irq_req    (irq_req),
    .in_delay   (in_delay),
    .sr_in      (sr_in),
    .vbr_in     (vbr_in),
    .taken      (taken),
    .reset_req  (reset_req),
    .pc_out     (pc_out),
    .sr_out     (sr_out),
    .expevt_out (expevt_out),
    .intevt_out (intevt_out)
);

// File: tb/sim_exc_entry_seq.sv
// Bench: behavioural reference model updated at each rising edge,
// compared against every output at each falling edge.
module sim_exc_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_valid = 1'b0;
    logic [11:0] exc_code = '0;
    logic        irq_req = 1'b0;
    logic [3:0]  irq_level = '0;
    logic [11:0] irq_code = '0;
    logic [31:0] sr_in = '0, pc_in = '0, r15_in = '0, vbr_in = '0;
    logic        in_delay = 1'b0, in_sleep = 1'b0;

    logic        taken, reset_req, dslot_clr;
    logic [31:0] pc_out, sr_out, ssr_out, spc_out, sgr_out;
    logic [11:0] expevt_out, intevt_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // expected state
    logic        e_taken, e_rr, e_dc;
    logic [31:0] e_pc, e_sr, e_ssr, e_spc, e_sgr;
    logic [11:0] e_exp, e_int;
    string       tag = "R1";
    string       spc_tag = "R1";

    always #4 clk = ~clk;

    exc_entry_seq u0 (
        .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
        .irq_req(irq_req), .irq_level(irq_level), .irq_code(irq_code),
        .sr_in(sr_in), .pc_in(pc_in), .r15_in(r15_in), .vbr_in(vbr_in),
        .in_delay(in_delay), .in_sleep(in_sleep),
        .taken(taken), .reset_req(reset_req), .dslot_clr(dslot_clr),
        .pc_out(pc_out), .sr_out(sr_out), .ssr_out(ssr_out), .spc_out(spc_out),
        .sgr_out(sgr_out), .expevt_out(expevt_out), .intevt_out(intevt_out)
    );

    // reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            e_taken = 0; e_rr = 0; e_dc = 0;
            e_pc = 32'hA000_0000; e_sr = 32'h1000_00F0;
            e_ssr = 0; e_spc = 0; e_sgr = 0; e_exp = 0; e_int = 0;
            tag = "R1"; spc_tag = "R1";
        end else begin
            e_taken = 0; e_rr = 0; e_dc = 0;
            spc_tag = "R11";
            if (exc_valid) begin
                tag = irq_req ? "R2" : "R9";
                if (sr_in[28] && exc_code != 12'h1E0) begin
                    e_rr = 1; tag = "R3";
                end else begin
                    e_taken = 1; e_dc = in_delay;
                    e_ssr = sr_in; e_sgr = r15_in; e_exp = exc_code;
                    e_sr = sr_in | 32'h7000_0000;
                    e_spc = pc_in;
                    spc_tag = "R9";
                    if (in_delay) begin e_spc = e_spc - 2; spc_tag = "R7"; end
                    if (exc_code == 12'h160) e_spc = e_spc + 2;
                    if (exc_code == 12'h000 || exc_code == 12'h020 || exc_code == 12'h140) begin
                        e_pc = 32'hA000_0000;
                        e_sr = (e_sr & ~32'h8000) | 32'hF0;
                        tag = "R8";
                    end else if (exc_code == 12'h040 || exc_code == 12'h060)
                        e_pc = vbr_in + 32'h400;
                    else
                        e_pc = vbr_in + 32'h100;
                end
            end else if (irq_req) begin
                if (in_delay || (sr_in[28] && !in_sleep)) tag = "R4";
                else if (int'(irq_level) <= int'(sr_in[7:4])) tag = "R5";
                else begin
                    tag = "R10"; spc_tag = in_delay ? "R7" : "R10";
                    e_taken = 1;
                    e_ssr = sr_in; e_sgr = r15_in; e_int = irq_code;
                    e_sr = sr_in | 32'h7000_0000;
                    e_spc = pc_in;
                    e_pc = vbr_in + 32'h600;
                end
            end else begin
                tag = "R11";
            end
        end
    end

    task automatic chk(input string rq, input string nm, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", rq, nm, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(tag, "taken", 32'(taken), 32'(e_taken));
        chk(tag, "reset_req", 32'(reset_req), 32'(e_rr));
        chk(tag, "dslot_clr", 32'(dslot_clr), 32'(e_dc));
        chk(tag, "pc_out", pc_out, e_pc);
        chk(tag, "sr_out", sr_out, e_sr);
        chk("R6", "ssr_out", ssr_out, e_ssr);
        chk("R6", "sgr_out", sgr_out, e_sgr);
        chk(spc_tag, "spc_out", spc_out, e_spc);
        chk(tag, "expevt_out", 32'(expevt_out), 32'(e_exp));
        chk(tag, "intevt_out", 32'(intevt_out), 32'(e_int));
    endtask

    task automatic drive(input bit ev, input logic [11:0] ec, input bit iq, input logic [3:0] lv,
                         input logic [31:0] sr, input bit dl, input bit sl);
        exc_valid = ev; exc_code = ec; irq_req = iq; irq_level = lv;
        irq_code = 12'h200 + 12'($urandom_range(0, 255));
        sr_in = sr; pc_in = $urandom & 32'hFFFF_FFFE; r15_in = $urandom;
        vbr_in = $urandom & 32'hFFFF_F000; in_delay = dl; in_sleep = sl;
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    function automatic logic [11:0] pick_code();
        int k = $urandom_range(0, 9);
        case (k)
            0: return 12'h000; 1: return 12'h020; 2: return 12'h140;
            3: return 12'h040; 4: return 12'h060; 5: return 12'h160;
            6: return 12'h1E0; 7: return 12'h0A0; 8: return 12'h180;
            default: return 12'h100;
        endcase
    endfunction

    initial begin
        // R1 reset values observed while reset is held
        drive(1, 12'h040, 1, 4'hF, 32'h0, 0, 0);
        repeat (3) step();
        @(negedge clk); rst_n = 1'b1;
        drive(0, 0, 0, 0, 32'h0, 0, 0);                                  step(); // R11 idle
        drive(1, 12'h040, 1, 4'hF, 32'h0000_8000, 0, 0);                 step(); // R2
        drive(1, 12'h0A0, 0, 0, 32'h1000_0000, 0, 0);                    step(); // R3
        drive(1, 12'h1E0, 0, 0, 32'h1000_0000, 0, 0);                    step(); // R3 permitted code
        drive(0, 0, 1, 4'h5, 32'h0000_0050, 0, 0);                       step(); // R5 equal level
        drive(0, 0, 1, 4'h6, 32'h0000_0050, 0, 0);                       step(); // R10
        drive(0, 0, 1, 4'hF, 32'h0000_0000, 1, 0);                       step(); // R4 delay slot
        drive(0, 0, 1, 4'hF, 32'h1000_0000, 0, 0);                       step(); // R4 block, awake
        drive(0, 0, 1, 4'hF, 32'h1000_0000, 0, 1);                       step(); // R4 block, sleeping
        drive(1, 12'h160, 0, 0, 32'h0, 1, 0);                            step(); // R7 with trap
        drive(1, 12'h020, 0, 0, 32'h0000_8030, 0, 0);                    step(); // R8
        drive(1, 12'h060, 0, 0, 32'h0, 0, 0);                            step(); // R9
        for (int i = 0; i < 4000; i++) begin
            drive($urandom_range(0, 9) < 3, pick_code(), $urandom_range(0, 9) < 5,
                  4'($urandom), $urandom & 32'h7000_80F3 | (32'($urandom_range(0, 3) == 0) << 28),
                  $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0);
            step();
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // watchdog
    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule